// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block resolves a translation miss by walking a two-level page table held in memory. A client presents a virtual address. The walker forms the address of the first-level entry from its table base register. It reads that entry over a single-word request/response memory port and decodes it. The entry can describe a whole 1 MB or 16 MB region, point to a second-level table, or mark the mapping as absent. When the entry points to a second-level table, the walker reads and decodes one more word, which describes a 4 KB page, a 64 KB page or an absent mapping.

The outcome is a physical page base, a page size code and three attribute fields (byte order, element size, mixed-size flag), ready to be loaded into a TLB. When the walk fails instead, the block reports a translation fault together with the faulting virtual address and the level at which the walk stopped. The attribute fields sit at different bit positions at each level. The walker moves them into one common output format.

Top module: `tw_walker`

## Requirements
- R1: A write to the table base register stores bits 31:7 of the written word, clears bits 6:0, and shows the stored value on `ttb_value`. After reset the register is zero.
- R2: The first memory read of a walk targets the word address {base[31:14], VA[31:20], 2'b00}.
- R3: A first-level entry with bits 1:0 = 2'b10 and bit 18 = 0 gives a 1 MB result: base {entry[31:20], 20'b0}, size code 2, byte order from bit 15, element size from bits 11:10 and mixed flag from bit 17.
- R4: A first-level entry with bits 1:0 = 2'b10 and bit 18 = 1 gives a 16 MB result: base {entry[31:24], 24'b0}, size code 3, with the attributes taken from the same bits as in R3. Whichever of the 16 replicated slots the VA selects, the result is the same.
- R5: A first-level entry with bits 1:0 = 2'b01 triggers a second read at {entry[31:10], VA[19:12], 2'b00}.
- R6: A second-level entry with bits 1:0 = 2'b10 gives a 4 KB result: base {entry[31:12], 12'b0}, size code 0, byte order from bit 9, element size from bits 5:4 and mixed flag from bit 11.
- R7: A second-level entry with bits 1:0 = 2'b01 gives a 64 KB result: base {entry[31:16], 16'b0}, size code 1, with the attributes taken from the same bits as in R6. Any of the 16 replicated slots gives the same result.
- R8: A first-level entry with bits 1:0 equal to 2'b00 (an all-zero entry included) or 2'b11 ends the walk with `fault` = 1, `fault_level` = 0 and `fault_va` equal to the request VA. No second read is issued.
- R9: A second-level entry with bits 1:0 equal to 2'b00 or 2'b11 ends the walk with `fault` = 1, `fault_level` = 1 and `fault_va` equal to the request VA.
- R10: The walker accepts `req_valid` only while `busy` is low. `busy` rises in the cycle after acceptance and stays high up to and including the single cycle in which `done` is high. A request presented while busy is ignored.
- R11: Each memory read is a one-cycle `mem_req` pulse with a word-aligned address. The next read is issued only after `mem_rvalid` has returned the previous word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ttb_we | input | 1 | Write strobe for the table base register |
| ttb_wdata | input | 32 | Value written to the table base register |
| ttb_value | output | 32 | Current table base register contents |
| req_valid | input | 1 | Walk request |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory read request pulse |
| mem_addr | output | 32 | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (table entry) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| fault_level | output | 1 | Level of the faulting entry (0 first, 1 second) |
| fault_va | output | 32 | Virtual address of the faulting walk |
| pa_base | output | 32 | Physical page base |
| page_size | output | 2 | Size code: 0 4 KB, 1 64 KB, 2 1 MB, 3 16 MB |
| attr_endian | output | 1 | Byte order attribute |
| attr_elsize | output | 2 | Element size attribute |
| attr_mixed | output | 1 | Mixed-size attribute |

## Verification
Directed walks cover each entry kind once with hand-picked values: a 1 MB region, a 16 MB region reached through a non-zero replica slot, 4 KB and 64 KB pages, and faults at both levels from zero and from 2'b11 entries. Together these show whether the type bits, bit 18 and the per-level attribute positions are decoded correctly. Random walks fill every bit an entry does not define with noise, so any decoding that depends on a don't-care bit shows up as a mismatch. They also vary memory latency and the VA bits that pick the replica slot. A walk that reads from a wrongly formed address fetches an empty word and faults, which exposes address-formation errors. A second request held high during a slow walk must leave the result and the following idle state unchanged.

// File: rtl/twalk_pkg.sv
// Package: shared types and bit positions for the translation table walker.
// Assumes 32-bit virtual and physical addresses and 32-bit table entries.
package twalk_pkg;

    localparam int WORD_W      = 32;
    localparam int TTB_KEEP_LSB = 7;   // base register bits below this are dropped
    localparam int L1_BASE_LSB = 14;   // first-level table alignment
    localparam int L1_IDX_LSB  = 20;   // VA bits 31:20 index the first level
    localparam int L2_BASE_LSB = 10;   // second-level table alignment
    localparam int L2_IDX_LSB  = 12;   // VA bits 19:12 index the second level
    localparam int SUPER_BIT   = 18;   // first-level bit telling 16 MB from 1 MB

    typedef enum logic [1:0] {
        SZ_4K  = 2'd0,
        SZ_64K = 2'd1,
        SZ_1M  = 2'd2,
        SZ_16M = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        K_FAULT = 2'd0,
        K_LEAF  = 2'd1,
        K_NEXT  = 2'd2
    } dkind_e;

    typedef struct packed {
        dkind_e           kind;
        logic [WORD_W-1:0] base;
        pg_size_e         size;
        logic             endian;
        logic [1:0]       elsize;
        logic             mixed;
    } desc_info_t;

endpackage

// File: rtl/tw_desc_decode.sv
// Module: decodes one table entry into kind, base, size and attributes.
// LEVEL selects the first-level or second-level layout. Purely combinational.
module tw_desc_decode
    import twalk_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  logic [WORD_W-1:0] desc,
    output desc_info_t        info
);

    generate
        if (LEVEL == 1) begin : g_first
            logic unused_l1;
            assign unused_l1 = ^desc[9:2];

            // Decode the first-level layout: region, table pointer or fault.
            always_comb begin
                info = '0;
                info.kind = K_FAULT;
                case (desc[1:0])
                    2'b10: begin
                        info.kind   = K_LEAF;
                        info.endian = desc[15];
                        info.elsize = desc[11:10];
                        info.mixed  = desc[17];
                        if (desc[SUPER_BIT]) begin
                            info.size = SZ_16M;
                            info.base = {desc[31:24], 24'b0};
                        end else begin
                            info.size = SZ_1M;
                            info.base = {desc[31:20], 20'b0};
                        end
                    end
                    2'b01: begin
                        info.kind = K_NEXT;
                        info.base = {desc[31:L2_BASE_LSB], {L2_BASE_LSB{1'b0}}};
                    end
                    default: info.kind = K_FAULT;
                endcase
            end
        end else begin : g_second
            logic unused_l2;
            assign unused_l2 = ^{desc[10], desc[8:6], desc[3:2]};

            // Decode the second-level layout: small page, large page or fault.
            always_comb begin
                info = '0;
                info.kind   = K_FAULT;
                info.endian = desc[9];
                info.elsize = desc[5:4];
                info.mixed  = desc[11];
                case (desc[1:0])
                    2'b10: begin
                        info.kind = K_LEAF;
                        info.size = SZ_4K;
                        info.base = {desc[31:12], 12'b0};
                    end
                    2'b01: begin
                        info.kind = K_LEAF;
                        info.size = SZ_64K;
                        info.base = {desc[31:16], 16'b0};
                    end
                    default: info.kind = K_FAULT;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/tw_addr_gen.sv
// Module: forms the word address of the entry to fetch at either level.
// Assumes the base inputs are already aligned; the low bits are ignored.
module tw_addr_gen
    import twalk_pkg::*;
(
    input  logic [WORD_W-1:0] ttb,
    input  logic [WORD_W-1:0] va,
    input  logic [WORD_W-1:0] tbl_base,
    input  logic              use_l2,
    output logic [WORD_W-1:0] addr
);

    localparam int L1_IDX_W = WORD_W - L1_IDX_LSB;
    localparam int L2_IDX_W = L1_IDX_LSB - L2_IDX_LSB;

    logic unused_bits;
    assign unused_bits = ^{ttb[L1_BASE_LSB-1:0], va[L2_IDX_LSB-1:0],
                           tbl_base[L2_BASE_LSB-1:0]};

    // Pick the index field and base for the requested level.
    always_comb begin
        if (use_l2)
            addr = {tbl_base[WORD_W-1:L2_BASE_LSB],
                    va[L2_IDX_LSB +: L2_IDX_W], 2'b00};
        else
            addr = {ttb[WORD_W-1:L1_BASE_LSB],
                    va[L1_IDX_LSB +: L1_IDX_W], 2'b00};
    end

endmodule

// File: rtl/tw_walker.sv
// Module: two-level table walker top. One walk at a time: latch the VA,
// read the first-level entry, optionally read the second-level entry,
// then present the result or fault for one cycle on done.
// Assumes the memory answers every mem_req with exactly one mem_rvalid.
module tw_walker
    import twalk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ttb_we,
    input  logic [WORD_W-1:0] ttb_wdata,
    output logic [WORD_W-1:0] ttb_value,
    input  logic              req_valid,
    input  logic [WORD_W-1:0] req_va,
    output logic              busy,
    output logic              mem_req,
    output logic [WORD_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic              fault,
    output logic              fault_level,
    output logic [WORD_W-1:0] fault_va,
    output logic [WORD_W-1:0] pa_base,
    output logic [1:0]        page_size,
    output logic              attr_endian,
    output logic [1:0]        attr_elsize,
    output logic              attr_mixed
);

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_ISSUE, ST_L1_WAIT, ST_L2_ISSUE, ST_L2_WAIT, ST_RESP
    } state_e;

    state_e            state, state_nx;
    logic [WORD_W-1:0] ttb_q, va_q, tbl_q;
    desc_info_t        l1_info, l2_info;
    logic              l1_hit, l2_hit;

    // Table base register: drops the low bits on every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ttb_q <= '0;
        else if (ttb_we)
            ttb_q <= {ttb_wdata[WORD_W-1:TTB_KEEP_LSB], {TTB_KEEP_LSB{1'b0}}};
    end

    tw_desc_decode #(.LEVEL(1)) u_dec_l1 (.desc(mem_rdata), .info(l1_info));
    tw_desc_decode #(.LEVEL(2)) u_dec_l2 (.desc(mem_rdata), .info(l2_info));

    tw_addr_gen u_addr (
        .ttb      (ttb_q),
        .va       (va_q),
        .tbl_base (tbl_q),
        .use_l2   (state == ST_L2_ISSUE),
        .addr     (mem_addr)
    );

    assign l1_hit = (state == ST_L1_WAIT) && mem_rvalid;
    assign l2_hit = (state == ST_L2_WAIT) && mem_rvalid;

    // Next-state logic of the walk sequence.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:     if (req_valid) state_nx = ST_L1_ISSUE;
            ST_L1_ISSUE: state_nx = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rvalid)
                             state_nx = (l1_info.kind == K_NEXT) ? ST_L2_ISSUE : ST_RESP;
            ST_L2_ISSUE: state_nx = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rvalid) state_nx = ST_RESP;
            ST_RESP:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Walk context: VA on acceptance, table pointer after a first-level hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q  <= '0;
            tbl_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) va_q <= req_va;
            if (l1_hit && l1_info.kind == K_NEXT) tbl_q <= l1_info.base;
        end
    end

    // Result registers: loaded from whichever level ends the walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault       <= 1'b0;
            fault_level <= 1'b0;
            pa_base     <= '0;
            page_size   <= '0;
            attr_endian <= 1'b0;
            attr_elsize <= '0;
            attr_mixed  <= 1'b0;
        end else if (l1_hit && l1_info.kind != K_NEXT) begin
            fault       <= (l1_info.kind == K_FAULT);
            fault_level <= 1'b0;
            pa_base     <= l1_info.base;
            page_size   <= l1_info.size;
            attr_endian <= l1_info.endian;
            attr_elsize <= l1_info.elsize;
            attr_mixed  <= l1_info.mixed;
        end else if (l2_hit) begin
            fault       <= (l2_info.kind == K_FAULT);
            fault_level <= 1'b1;
            pa_base     <= l2_info.base;
            page_size   <= l2_info.size;
            attr_endian <= l2_info.endian;
            attr_elsize <= l2_info.elsize;
            attr_mixed  <= l2_info.mixed;
        end
    end

    assign ttb_value = ttb_q;
    assign fault_va  = va_q;
    assign busy      = (state != ST_IDLE);
    assign done      = (state == ST_RESP);
    assign mem_req   = (state == ST_L1_ISSUE) || (state == ST_L2_ISSUE);

    // R1: the stored base never carries the dropped low bits.
    a_r1_ttb_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ttb_value[TTB_KEEP_LSB-1:0] == '0);

    // R10: an accepted request makes the walker busy on the next cycle.
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R10: the done pulse releases the walker.
    a_r10_done_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    // R10: no memory traffic while idle.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R11: a read request is a single-cycle pulse.
    a_r11_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R11: read addresses are word aligned.
    a_r11_word_align: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R8: a first-level fault completes without a second read.
    a_r8_no_l2_after_l1_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (done && fault && !fault_level) |-> !$past(mem_req));

endmodule

// File: tb/tb_tw_walker.sv
// Bench for tw_walker: directed corner cases plus seeded random walks,
// checked against a model computed from the requirements.
module tb_tw_walker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ttb_we;
    logic [31:0] ttb_wdata, ttb_value;
    logic        req_valid;
    logic [31:0] req_va;
    logic        busy, mem_req, mem_rvalid, done, fault, fault_level;
    logic [31:0] mem_addr, mem_rdata, fault_va, pa_base;
    logic [1:0]  page_size, attr_elsize;
    logic        attr_endian, attr_mixed;

    int checks = 0;
    int fails  = 0;
    int lat    = 1;
    bit finished = 0;
    logic [31:0] ttb_m;
    logic [31:0] mem [logic [31:0]];

    always #2.5 clk = ~clk;

    tw_walker dut (.*);

    typedef struct {
        logic        f;
        logic        lvl;
        logic [31:0] pa;
        logic [1:0]  sz;
        logic        e;
        logic [1:0]  es;
        logic        m;
    } exp_t;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // Expected result from the requirement text (R2..R9).
    function automatic exp_t model(input logic [31:0] va);
        exp_t x;
        logic [31:0] d1, d2;
        x = '{default: '0};
        d1 = rd({ttb_m[31:14], va[31:20], 2'b00});
        if (d1[1:0] == 2'b10) begin
            x.e = d1[15]; x.es = d1[11:10]; x.m = d1[17];
            if (d1[18]) begin x.sz = 2'd3; x.pa = {d1[31:24], 24'h0}; end
            else        begin x.sz = 2'd2; x.pa = {d1[31:20], 20'h0}; end
        end else if (d1[1:0] == 2'b01) begin
            d2 = rd({d1[31:10], va[19:12], 2'b00});
            x.e = d2[9]; x.es = d2[5:4]; x.m = d2[11];
            if (d2[1:0] == 2'b10)      begin x.sz = 2'd0; x.pa = {d2[31:12], 12'h0}; end
            else if (d2[1:0] == 2'b01) begin x.sz = 2'd1; x.pa = {d2[31:16], 16'h0}; end
            else begin x.f = 1; x.lvl = 1; end
        end else begin
            x.f = 1; x.lvl = 0;
        end
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory responder: answers each request after lat cycles.
    initial begin
        logic [31:0] a;
        int cnt;
        bit pend;
        mem_rvalid = 0; mem_rdata = '0; pend = 0; cnt = 0; a = '0;
        forever begin
            @(negedge clk);
            mem_rvalid = 0;
            if (mem_req === 1'b1) begin
                a = mem_addr; pend = 1; cnt = lat;
            end else if (pend) begin
                cnt--;
                if (cnt <= 0) begin
                    pend = 0; mem_rvalid = 1; mem_rdata = rd(a);
                end
            end
            if (pend && cnt <= 0) begin
                pend = 0; mem_rvalid = 1; mem_rdata = rd(a);
            end
        end
    end

    task automatic set_ttb(input logic [31:0] v);
        @(negedge clk); ttb_we = 1; ttb_wdata = v;
        @(negedge clk); ttb_we = 0;
        ttb_m = {v[31:7], 7'h0};
    endtask

    // Run one walk; hold_extra pulses a second request while busy.
    task automatic walk(input logic [31:0] va, input string tag, input bit hold_extra);
        exp_t x;
        int n;
        x = model(va);
        @(negedge clk); req_valid = 1; req_va = va;
        @(negedge clk);
        chk(busy === 1'b1, "R10 busy after accept", {63'h0, busy}, 64'h1);
        if (hold_extra) req_va = va ^ 32'hFFF0_0000;
        else req_valid = 0;
        n = 0;
        while (done !== 1'b1 && n < 400) begin
            @(negedge clk); n++;
            if (n == 3) req_valid = 0;
        end
        req_valid = 0;
        chk(done === 1'b1, {tag, " done seen"}, {63'h0, done}, 64'h1);
        if (x.f) begin
            chk(fault === 1'b1 && fault_level === x.lvl && fault_va === va, tag,
                {31'h0, fault, 31'h0, fault_level}, {31'h0, 1'b1, 31'h0, x.lvl});
            chk(fault_va === va, {tag, " fault_va"}, {32'h0, fault_va}, {32'h0, va});
        end else begin
            chk(fault === 1'b0 && {pa_base, page_size, attr_endian, attr_elsize, attr_mixed}
                === {x.pa, x.sz, x.e, x.es, x.m}, tag,
                {26'h0, fault, pa_base, page_size, attr_endian, attr_elsize, attr_mixed},
                {27'h0, x.pa, x.sz, x.e, x.es, x.m});
        end
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 release after done",
            {62'h0, busy, done}, 64'h0);
        if (hold_extra) begin
            repeat (4) @(negedge clk);
            chk(busy === 1'b0, "R10 request while busy ignored", {63'h0, busy}, 64'h0);
        end
    endtask

    // Random scenario builder; kind picks the entry type under test.
    task automatic build(input int kind, input logic [31:0] va);
        logic [31:0] d, t, l1a, l2a;
        mem.delete();
        l1a = {ttb_m[31:14], va[31:20], 2'b00};
        d = $urandom;
        case (kind)
            0: begin d[1:0] = 2'b10; d[18] = 0; mem[l1a] = d; end
            1: begin d[1:0] = 2'b10; d[18] = 1;
                   for (int i = 0; i < 16; i++)
                       mem[{ttb_m[31:14], va[31:24], i[3:0], 2'b00}] = d; end
            2, 3, 5: begin
                   d[1:0] = 2'b01; mem[l1a] = d;
                   l2a = {d[31:10], va[19:12], 2'b00};
                   t = $urandom;
                   if (kind == 2) begin t[1:0] = 2'b10; mem[l2a] = t; end
                   else if (kind == 3) begin
                       t[1:0] = 2'b01;
                       for (int i = 0; i < 16; i++)
                           mem[{d[31:10], va[19:16], i[3:0], 2'b00}] = t;
                   end else mem[l2a] = ($urandom % 2) ? 32'h0 : {t[31:2], 2'b11};
               end
            default: mem[l1a] = ($urandom % 2) ? 32'h0 : {d[31:2], 2'b00};
        endcase
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] va, d;
        void'($urandom(32'h1D2C));
        rst_n = 0; ttb_we = 0; ttb_wdata = '0; req_valid = 0; req_va = '0; ttb_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(busy === 0 && done === 0 && mem_req === 0, "R10 reset idle",
            {61'h0, busy, done, mem_req}, 64'h0);
        chk(ttb_value === 32'h0, "R1 reset base", {32'h0, ttb_value}, 64'h0);

        set_ttb(32'hFFFF_FFFF);
        chk(ttb_value === 32'hFFFF_FF80, "R1 low bits dropped", {32'h0, ttb_value}, 64'hFFFF_FF80);
        set_ttb(32'h8000_40D5);
        chk(ttb_value === 32'h8000_4080, "R1 base stored", {32'h0, ttb_value}, 64'h8000_4080);

        // R2 R3: 1 MB region with literal expectation.
        mem.delete();
        va = 32'h1234_5678;
        mem[{ttb_m[31:14], va[31:20], 2'b00}] = 32'hABC2_8C02;
        walk(va, "R3 section", 0);
        chk(pa_base === 32'hABC0_0000 && page_size === 2 && attr_endian && attr_elsize === 3
            && attr_mixed, "R3 section literal", {32'h0, pa_base}, 64'hABC0_0000);

        // R4: 16 MB region, VA lands on replica slot 5.
        lat = 3;
        va = 32'h4750_1234; build(1, va); walk(va, "R4 supersection slot5", 0);
        // R5 R6: 4 KB page through a table.
        va = 32'h0ACE_F123; build(2, va); walk(va, "R6 small page", 0);
        // R7: 64 KB page, replica slot 9.
        va = 32'h3339_9000; build(3, va); walk(va, "R7 large page slot9", 0);
        // R8: zero first-level entry, then a 2'b11 entry.
        lat = 1;
        va = 32'h9000_0000; mem.delete(); walk(va, "R8 l1 zero fault", 0);
        mem[{ttb_m[31:14], va[31:20], 2'b00}] = 32'h1234_5673;
        walk(va, "R8 l1 type3 fault", 0);
        // R9: zero second-level entry.
        mem.delete(); mem[{ttb_m[31:14], va[31:20], 2'b00}] = 32'h5555_5401;
        walk(va, "R9 l2 zero fault", 0);
        // R10: extra request while busy, slow memory.
        lat = 4;
        va = 32'h0ACE_F123; build(2, va); walk(va, "R10 ignore second req", 1);

        // Random walks across all kinds and latencies (R2..R9, R11).
        for (int k = 0; k < 300; k++) begin
            if (k % 50 == 0) begin d = $urandom; set_ttb(d); end
            lat = 1 + ($urandom % 3);
            va = $urandom;
            build($urandom % 6, va);
            walk(va, "R11 random walk", 0);
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule